// File: doc/BRIEF.md
# Power-up strap capture and pin-role sequencer

This block takes a set of configuration straps that share pins with clock outputs and turns them into a stable configuration word at power-up. Five frequency-select straps and one multiplier strap are read as inputs while the supply is still settling. The first time the power-good line goes high, all six straps are captured in one clock. In that same clock every shared pin is handed over from input duty to driving its clock.

From then on the power-good line has a second job. It serves as an active-low power-down request. Driving it low asks the device to enter power-down, and driving it high again releases the request. The captured word stays the same across any number of power-down cycles. Only a reset clears it.

The power-good line is asynchronous to the block clock. It passes through a synchronizer before any decision is made on it. The strap pins are assumed static around the capture, as straps normally are. When left undriven, the straps rest low, and the multiplier and power-good lines rest high.

Top module: `pwrup_strap_seq`

## Requirements
- R1: While `rstN` is low and right after its release, `strapWord`, `pinDriveEn` and `powerDownReq` are all zero.
- R2: If `pwrGoodPin` is first sampled high at clock edge k, after a low sample, the straps are captured into `strapWord` at edge k+2 and not earlier. Here k counts only edges after reset.
- R3: Bits [NUM_FS-1:0] of `strapWord` hold `fsStrap` bit for bit, and bit NUM_FS holds `multStrap`.
- R4: All bits of `pinDriveEn` rise together on the capture edge and never fall until reset.
- R5: After capture, neither later rising edges of `pwrGoodPin` nor changes on the strap inputs alter `strapWord`.
- R6: After capture, if `pwrGoodPin` is sampled low at edge k, `powerDownReq` is high after edge k+1.
- R7: After capture, if `pwrGoodPin` is sampled high again at edge k, `powerDownReq` is low after edge k+1.
- R8: Before capture, `pwrGoodPin` being low never raises `powerDownReq`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rstN | input | 1 | Asynchronous active-low reset |
| fsStrap | input | NUM_FS | Frequency-select strap levels read from the shared pins |
| multStrap | input | 1 | Multiplier strap level |
| pwrGoodPin | input | 1 | Asynchronous power-good level, later an active-low power-down request |
| strapWord | output | NUM_FS+1 | Captured straps: {multiplier, frequency selects} |
| pinDriveEn | output | NUM_FS+1 | Per-pin enable that turns each shared pin into a driven clock |
| powerDownReq | output | 1 | Power-down request |

## Verification
Every result of this block lags the power-good sample that causes it by a fixed count of clock edges. The capture and the output-enable land two edges after the first high sample. The power-down request follows the line with one edge of lag after each sample, in either direction. The bench keeps a sample history of the power-good line, predicts each output from that history, and compares all outputs on every falling clock edge. At the exact edges around each transition, it also makes named checks that the value has not changed one cycle early and has changed on time.

// File: rtl/pwrup_strap_seq_pkg.sv
package pwrup_strap_seq_pkg;
  // Strobes sent from the control half to the datapath half
  typedef struct packed {
    logic capture;    // take straps and hand pins over to clock duty
    logic powerDown;  // active power-down request
  } seqStrobes_t;
endpackage

// File: rtl/pwrup_strap_seq_ctrl.sv
module pwrup_strap_seq_ctrl
  import pwrup_strap_seq_pkg::*;
#(
  parameter int SYNC_DEPTH = 2
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        pwrGoodPin,
  output seqStrobes_t strobes
);
  logic [SYNC_DEPTH-1:0] syncChain;
  logic pgSync;
  logic pgPrev;
  logic latchedQ;

  generate
    if (SYNC_DEPTH == 1) begin : g_single
      always_ff @(posedge clk or negedge rstN)
        if (!rstN) syncChain <= '0;
        else       syncChain <= pwrGoodPin;
    end else begin : g_multi
      always_ff @(posedge clk or negedge rstN)
        if (!rstN) syncChain <= '0;
        else       syncChain <= {syncChain[SYNC_DEPTH-2:0], pwrGoodPin};
    end
  endgenerate

  assign pgSync = syncChain[SYNC_DEPTH-1];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pgPrev   <= 1'b0;
      latchedQ <= 1'b0;
    end else begin
      pgPrev <= pgSync;
      if (strobes.capture) latchedQ <= 1'b1;
    end
  end

  always_comb begin
    strobes.capture   = !latchedQ && pgSync && !pgPrev;
    strobes.powerDown = latchedQ && !pgSync;
  end
endmodule

// File: rtl/pwrup_strap_seq_dpath.sv
module pwrup_strap_seq_dpath
  import pwrup_strap_seq_pkg::*;
#(
  parameter int NUM_FS = 5,
  localparam int WORD_W = NUM_FS + 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  seqStrobes_t       strobes,
  input  logic [NUM_FS-1:0] fsStrap,
  input  logic              multStrap,
  output logic [WORD_W-1:0] strapWord,
  output logic [WORD_W-1:0] pinDriveEn
);
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      strapWord  <= '0;
      pinDriveEn <= '0;
    end else if (strobes.capture) begin
      strapWord  <= {multStrap, fsStrap};
      pinDriveEn <= '1;
    end
  end
endmodule

// File: rtl/pwrup_strap_seq.sv
module pwrup_strap_seq
  import pwrup_strap_seq_pkg::*;
#(
  parameter int NUM_FS     = 5,
  parameter int SYNC_DEPTH = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [NUM_FS-1:0] fsStrap,
  input  logic              multStrap,
  input  logic              pwrGoodPin,
  output logic [NUM_FS:0]   strapWord,
  output logic [NUM_FS:0]   pinDriveEn,
  output logic              powerDownReq
);
  seqStrobes_t strobes;

  pwrup_strap_seq_ctrl #(.SYNC_DEPTH(SYNC_DEPTH)) u_ctrl (
    .clk(clk), .rstN(rstN), .pwrGoodPin(pwrGoodPin), .strobes(strobes)
  );

  pwrup_strap_seq_dpath #(.NUM_FS(NUM_FS)) u_dpath (
    .clk(clk), .rstN(rstN), .strobes(strobes),
    .fsStrap(fsStrap), .multStrap(multStrap),
    .strapWord(strapWord), .pinDriveEn(pinDriveEn)
  );

  assign powerDownReq = strobes.powerDown;
endmodule

// File: rtl/pwrup_strap_seq_chk.sv
module pwrup_strap_seq_chk #(
  parameter int NUM_FS = 5
) (
  input logic            clk,
  input logic            rstN,
  input logic            pwrGoodPin,
  input logic [NUM_FS:0] strapWord,
  input logic [NUM_FS:0] pinDriveEn,
  input logic            powerDownReq
);
  // R4: enables move as one group
  assert_enables_grouped_R4: assert property (@(posedge clk) disable iff (!rstN)
    (pinDriveEn == '0) || (pinDriveEn == '1));

  // R4: once driving, a pin keeps driving
  assert_enables_sticky_R4: assert property (@(posedge clk) disable iff (!rstN)
    pinDriveEn[0] |=> pinDriveEn[0]);

  // R5: captured word frozen after capture
  assert_word_frozen_R5: assert property (@(posedge clk) disable iff (!rstN)
    pinDriveEn[0] |=> $stable(strapWord));

  // R8: no power-down request before capture
  assert_no_early_pd_R8: assert property (@(posedge clk) disable iff (!rstN)
    powerDownReq |-> pinDriveEn[0]);

  // R6: a request only follows a low sample of the line
  assert_pd_follows_low_R6: assert property (@(posedge clk) disable iff (!rstN)
    $rose(powerDownReq) |-> !$past(pwrGoodPin, 2));
endmodule

bind pwrup_strap_seq pwrup_strap_seq_chk #(.NUM_FS(NUM_FS)) u_chk (.*);

// File: tb/tb_pwrup_strap_seq.sv
module tb_pwrup_strap_seq;
  localparam int NUM_FS = 5;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [NUM_FS-1:0] fsStrap = 5'b10110;
  logic multStrap = 1'b1;
  logic pwrGoodPin = 1'b0;
  logic [NUM_FS:0] strapWord;
  logic [NUM_FS:0] pinDriveEn;
  logic powerDownReq;

  int checks = 0;
  int errors = 0;
  bit running = 1'b0;
  bit finished = 1'b0;
  string curTag = "R1";

  always #2.5 clk = ~clk;

  pwrup_strap_seq #(.NUM_FS(NUM_FS)) dut (.*);

  // Reference model: history of power-good samples, newest first
  bit hist[$];
  bit latchedM = 1'b0;
  logic [NUM_FS:0] wordM = '0;

  initial begin
    hist = {1'b0, 1'b0, 1'b0};
  end

  always @(posedge clk) begin
    if (!rstN) begin
      hist = {1'b0, 1'b0, 1'b0};
      latchedM = 1'b0;
      wordM = '0;
    end else begin
      // hist[1] = line two samples back, hist[2] = three back
      if (!latchedM && hist[1] && !hist[2]) begin
        wordM = {multStrap, fsStrap};
        latchedM = 1'b1;
      end
      hist.push_front(pwrGoodPin);
      void'(hist.pop_back());
    end
  end

  task automatic check(string tag, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  // Continuous comparison on every falling edge
  always @(negedge clk) begin
    if (running) begin
      check(curTag, "model strapWord", 32'(strapWord), 32'(wordM));
      check(curTag, "model pinDriveEn", 32'(pinDriveEn), latchedM ? 32'h3f : 32'h0);
      check(curTag, "model powerDownReq", 32'(powerDownReq),
            32'(latchedM && !hist[1]));
    end
  end

  task automatic cyc(int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  initial begin
    cyc(3);
    check("R1", "reset strapWord", 32'(strapWord), 0);
    check("R1", "reset pinDriveEn", 32'(pinDriveEn), 0);
    rstN = 1'b1;
    running = 1'b1;
    cyc(1);
    check("R1", "post-reset powerDownReq", 32'(powerDownReq), 0);

    // R8: line low before capture
    curTag = "R8";
    cyc(6);
    check("R8", "no early request", 32'(powerDownReq), 0);

    // R2/R3/R4: first rising edge
    curTag = "R2";
    pwrGoodPin = 1'b1;
    cyc(1);                                  // sampled at edge k
    cyc(1);                                  // edge k+1
    check("R2", "no capture at k+1", 32'(pinDriveEn), 0);
    check("R2", "word empty at k+1", 32'(strapWord), 0);
    cyc(1);                                  // edge k+2
    check("R3", "captured word order", 32'(strapWord), 32'h36);
    check("R4", "all pins driving", 32'(pinDriveEn), 32'h3f);
    cyc(3);

    // R5: strap changes and new rising edge ignored
    curTag = "R5";
    fsStrap = 5'b01001;
    multStrap = 1'b0;
    cyc(3);
    check("R5", "strap change ignored", 32'(strapWord), 32'h36);

    // R6: power-down request
    curTag = "R6";
    pwrGoodPin = 1'b0;
    cyc(1);                                  // edge k
    check("R6", "no request at k", 32'(powerDownReq), 0);
    cyc(1);                                  // edge k+1
    check("R6", "request at k+1", 32'(powerDownReq), 1);
    cyc(4);

    // R7: release
    curTag = "R7";
    pwrGoodPin = 1'b1;
    cyc(1);
    check("R7", "still requested at k", 32'(powerDownReq), 1);
    cyc(1);
    check("R7", "released at k+1", 32'(powerDownReq), 0);
    cyc(3);
    check("R5", "no recapture", 32'(strapWord), 32'h36);
    check("R4", "pins stay driving", 32'(pinDriveEn), 32'h3f);

    // Several more power-down cycles
    curTag = "R5";
    for (int r = 0; r < 4; r++) begin
      pwrGoodPin = 1'b0;
      cyc(2 + r);
      pwrGoodPin = 1'b1;
      cyc(3);
    end
    check("R5", "word after power cycles", 32'(strapWord), 32'h36);

    running = 1'b0;
    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #100000;
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual hung expected done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule